// File: doc/BRIEF.md
# Secure Illegal-Access Interrupt Controller

This block gathers single-cycle illegal-access pulses from a set of protected sources (memories, DMA engines, crypto units, a radio SPI port, the power unit and the controller itself) and reports them on one interrupt line. Each pulse sets a sticky per-source status flag. A 32-bit mask register, reached over a small register bus, decides which flags may raise the interrupt. Software reads the flags and clears them by writing ones.

Every register access carries a security attribute and a privilege attribute. Only an access that is both secure and privileged takes effect. Any other access is dropped, reads zero, and counts as an illegal access against the controller's own source bit. A global security-enable input selects the reset value of the mask register. While that input is low, the block's registers ignore writes, read zero and raise no event of their own.

Register words sit at byte offsets 0x0 (mask), 0x4 (status, read-only) and 0x8 (write-one-to-clear). Source bit positions are fixed:

| Bit | Source |
|-----|--------|
| 0 | controller itself |
| 1 | security configuration unit |
| 2 | AES |
| 3 | RNG |
| 4 | radio SPI |
| 5 | power |
| 6 | flash interface |
| 7 | DMA1 |
| 8 | DMA2 |
| 9 | DMA mux |
| 10 | flash memory |
| 11 | SRAM1 |
| 12 | SRAM2 |
| 13 | PKA |

Top module: `sec_fault_irq_ctrl`

## Requirements
- R1: After a synchronous reset the mask bits 13:0 are all ones if `sec_enable` is high during reset and all zeros otherwise. The status flags are zero, and `irq`, `rsp_valid` and `rsp_rdata` are zero.
- R2: A permitted write to offset 0x0 updates only the mask bits whose byte lane strobe is set. Strobe bit k covers data bits 8k+7:8k. Bits 31:14 cannot be changed, and while security is enabled they read as ones.
- R3: An access that is not both secure (`req_secure`=1) and privileged (`req_priv`=1) leaves every register unchanged and returns zero read data.
- R4: While `sec_enable` is high, a rejected access to any offset sets status bit 0 at the same clock edge as the access.
- R5: While `sec_enable` is low, writes are ignored, the mask holds zero, every read returns zero, and no access sets status bit 0.
- R6: A high `src_evt[i]` sets status bit i whether or not mask bit i is set. The flag stays set until it is cleared. Status reads at offset 0x4, in bits 13:0.
- R7: A permitted write to offset 0x8 clears each status bit whose data bit is one and whose byte lane strobe is set. Other bits keep their value.
- R8: If an event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R9: `irq` equals the OR over all sources of status AND mask, taken one clock edge later.
- R10: For every read request, `rsp_valid` is high in the following cycle, with the read data on `rsp_rdata`. Outside read responses, `rsp_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_enable | input | 1 | Global security enable |
| src_evt | input | 14 | Illegal-access event pulses, one per source |
| req_valid | input | 1 | Register request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte address of the register word |
| req_wdata | input | 32 | Write data |
| req_strb | input | 4 | Byte lane write strobes |
| req_secure | input | 1 | Requester is secure |
| req_priv | input | 1 | Requester is privileged |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 32 | Read response data |
| irq | output | 1 | Registered interrupt output |

## Verification
The bench builds the block with its default parameters: fourteen sources, a four-bit byte address and the controller's own flag at bit 0. With these values every source bit is reached, and the mask spans two byte lanes, so partial-strobe writes affect some mask bits and leave others alone. The lanes holding only reserved bits show that the reserved field cannot be written. Reset under each setting of the security-enable input reaches both reset values of the mask. It also covers the disabled mode, with its zero reads and absence of self-reported events. Random attribute mixes then drive rejected accesses against concurrent events and clears.

// File: rtl/sfic_pkg.sv
`timescale 1ns/1ps
package sfic_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned STRB_W = REG_W / LANE_W;

  typedef enum logic [1:0] {
    SEL_MASK   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_CLEAR  = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/sfic_access_filter.sv
`timescale 1ns/1ps
module sfic_access_filter
  import sfic_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              sec_enable,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_secure,
  input  logic              req_priv,
  output logic              wr_grant,
  output logic              rd_grant,
  output logic              rd_req,
  output logic              reject,
  output reg_sel_e          sel
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic             trusted;
  logic [IDX_W-1:0] word_idx;

  assign trusted  = req_secure & req_priv;
  assign word_idx = req_addr[ADDR_W-1:2];

  always_comb begin
    sel = SEL_NONE;
    if (req_addr[1:0] == 2'b00) begin
      if (word_idx == IDX_W'(0))      sel = SEL_MASK;
      else if (word_idx == IDX_W'(1)) sel = SEL_STATUS;
      else if (word_idx == IDX_W'(2)) sel = SEL_CLEAR;
    end
  end

  assign wr_grant = req_valid & req_write & sec_enable & trusted;
  assign rd_grant = req_valid & ~req_write & sec_enable & trusted;
  assign rd_req   = req_valid & ~req_write;
  assign reject   = req_valid & sec_enable & ~trusted;
endmodule

// File: rtl/sfic_mask_reg.sv
`timescale 1ns/1ps
module sfic_mask_reg
  import sfic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sec_enable,
  input  logic               wr_en,
  input  logic [NUM_SRC-1:0] wdata,
  input  logic [STRB_W-1:0]  strb,
  output logic [NUM_SRC-1:0] mask_q
);
  logic [NUM_SRC-1:0] lane_sel;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
    assign lane_sel[i] = strb[i / LANE_W];
  end

  always_ff @(posedge clk) begin
    if (rst)             mask_q <= {NUM_SRC{sec_enable}};
    else if (!sec_enable) mask_q <= '0;
    else if (wr_en)      mask_q <= (mask_q & ~lane_sel) | (wdata & lane_sel);
  end

  AST_MASK_ZERO_OFF: assert property (@(posedge clk) disable iff (rst)
    !sec_enable |=> (mask_q == '0)); // R5
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (sec_enable && !wr_en) |=> $stable(mask_q)); // R3
endmodule

// File: rtl/sfic_status_bank.sv
`timescale 1ns/1ps
module sfic_status_bank #(
  parameter int unsigned NUM_SRC = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] status_q
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)           status_q[i] <= 1'b0;
      else if (set_i[i]) status_q[i] <= 1'b1;
      else if (clr_i[i]) status_q[i] <= 1'b0;
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
      (status_q[i] && !clr_i[i]) |=> status_q[i]); // R6
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
      set_i[i] |=> status_q[i]); // R8
  end
endmodule

// File: rtl/sec_fault_irq_ctrl.sv
`timescale 1ns/1ps
module sec_fault_irq_ctrl
  import sfic_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 14,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned SELF_SRC = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sec_enable,
  input  logic [NUM_SRC-1:0] src_evt,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [REG_W-1:0]   req_wdata,
  input  logic [STRB_W-1:0]  req_strb,
  input  logic               req_secure,
  input  logic               req_priv,
  output logic               rsp_valid,
  output logic [REG_W-1:0]   rsp_rdata,
  output logic               irq
);
  localparam int unsigned RSV_W = REG_W - NUM_SRC;

  logic               wr_grant, rd_grant, rd_req, reject;
  reg_sel_e           sel;
  logic [NUM_SRC-1:0] mask_q, status_q, set_vec, clr_vec, lane_sel;
  logic [REG_W-1:0]   rd_word;
  logic               unused_wdata_hi;

  assign unused_wdata_hi = ^req_wdata[REG_W-1:NUM_SRC];

  sfic_access_filter #(.ADDR_W(ADDR_W)) u_filter (
    .sec_enable (sec_enable),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_secure (req_secure),
    .req_priv   (req_priv),
    .wr_grant   (wr_grant),
    .rd_grant   (rd_grant),
    .rd_req     (rd_req),
    .reject     (reject),
    .sel        (sel)
  );

  sfic_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk        (clk),
    .rst        (rst),
    .sec_enable (sec_enable),
    .wr_en      (wr_grant && sel == SEL_MASK),
    .wdata      (req_wdata[NUM_SRC-1:0]),
    .strb       (req_strb),
    .mask_q     (mask_q)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_clr_lane
    assign lane_sel[i] = req_strb[i / LANE_W];
  end

  assign clr_vec = (wr_grant && sel == SEL_CLEAR) ?
                   (req_wdata[NUM_SRC-1:0] & lane_sel) : '0;
  assign set_vec = src_evt | (NUM_SRC'(reject) << SELF_SRC);

  sfic_status_bank #(.NUM_SRC(NUM_SRC)) u_status (
    .clk      (clk),
    .rst      (rst),
    .set_i    (set_vec),
    .clr_i    (clr_vec),
    .status_q (status_q)
  );

  always_comb begin
    rd_word = '0;
    if (rd_grant) begin
      unique case (sel)
        SEL_MASK:   rd_word = {{RSV_W{1'b1}}, mask_q};
        SEL_STATUS: rd_word = {{RSV_W{1'b0}}, status_q};
        default:    rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      rsp_valid <= rd_req;
      rsp_rdata <= rd_word;
      irq       <= |(status_q & mask_q);
    end
  end

  AST_SELF_EVENT: assert property (@(posedge clk) disable iff (rst)
    reject |=> status_q[SELF_SRC]); // R4
  AST_REJECT_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !(sec_enable && req_secure && req_priv)) |=> (rsp_rdata == '0)); // R3
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (|(status_q & mask_q)) |=> irq); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(|(status_q & mask_q)) |=> !irq); // R9
  AST_RSP_TIMING: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rsp_valid); // R10
  AST_RSP_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (rsp_rdata == '0)); // R10
endmodule

// File: tb/sec_fault_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module sec_fault_irq_ctrl_tb_top;
  localparam int NSRC = 14;
  localparam int AW   = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            sec_enable = 1'b0;
  logic [NSRC-1:0] src_evt = '0;
  logic            req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0]   req_addr = '0;
  logic [31:0]     req_wdata = '0;
  logic [3:0]      req_strb = '0;
  logic            req_secure = 1'b0, req_priv = 1'b0;
  logic            rsp_valid, irq;
  logic [31:0]     rsp_rdata;

  always #2.5 clk = ~clk;

  sec_fault_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .sec_enable(sec_enable), .src_evt(src_evt),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_strb(req_strb), .req_secure(req_secure),
    .req_priv(req_priv), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  int              n_cmp = 0, n_bad = 0;
  bit              done = 1'b0;
  logic [NSRC-1:0] m_mask, m_stat;
  logic            m_irq, m_rv;
  logic [31:0]     m_rdata;

  function automatic logic [NSRC-1:0] lanes_of(input logic [3:0] s);
    logic [NSRC-1:0] r;
    for (int b = 0; b < NSRC; b++) r[b] = s[b / 8];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // One clock: drive at the falling edge, update the model at the rising edge, check at the next falling edge.
  task automatic cyc(input logic v, input logic w, input logic [AW-1:0] a,
                     input logic [31:0] d, input logic [3:0] s, input logic sc,
                     input logic pr, input logic [NSRC-1:0] ev, input string tag);
    logic ok, rej;
    logic [NSRC-1:0] lm, clr, setv;
    req_valid = v; req_write = w; req_addr = a; req_wdata = d; req_strb = s;
    req_secure = sc; req_priv = pr; src_evt = ev;
    @(posedge clk);
    ok   = sec_enable && sc && pr;
    rej  = v && sec_enable && !(sc && pr);
    lm   = lanes_of(s);
    m_irq = |(m_stat & m_mask);
    m_rv  = v && !w;
    m_rdata = '0;
    if (v && !w && ok && a[1:0] == 2'b00) begin
      if (a[3:2] == 2'd0) m_rdata = {{(32-NSRC){1'b1}}, m_mask};
      if (a[3:2] == 2'd1) m_rdata = {{(32-NSRC){1'b0}}, m_stat};
    end
    clr  = (v && w && ok && a == 4'h8) ? (d[NSRC-1:0] & lm) : '0;
    setv = ev | {{(NSRC-1){1'b0}}, rej};
    m_stat = (m_stat & ~clr) | setv;
    if (!sec_enable) m_mask = '0;
    else if (v && w && ok && a == 4'h0) m_mask = (m_mask & ~lm) | (d[NSRC-1:0] & lm);
    @(negedge clk);
    chk({tag, " rsp_valid (R10)"}, {31'd0, rsp_valid}, {31'd0, m_rv});
    chk({tag, " rdata"}, rsp_rdata, m_rdata);
    chk("R9 irq", {31'd0, irq}, {31'd0, m_irq});
    req_valid = 1'b0; src_evt = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic sc, input logic pr, input string tag);
    cyc(1'b1, 1'b0, a, 32'd0, 4'h0, sc, pr, '0, tag);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] s,
                    input logic sc, input logic pr, input string tag);
    cyc(1'b1, 1'b1, a, d, s, sc, pr, '0, tag);
  endtask

  task automatic idle(input logic [NSRC-1:0] ev, input string tag);
    cyc(1'b0, 1'b0, '0, 32'd0, 4'h0, 1'b1, 1'b1, ev, tag);
  endtask

  task automatic do_reset(input logic se);
    rst = 1'b1; sec_enable = se; req_valid = 1'b0; src_evt = '0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst = 1'b0;
    m_mask = {NSRC{se}}; m_stat = '0; m_irq = 1'b0; m_rv = 1'b0; m_rdata = '0;
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    chk("R1 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
    chk("R1 rdata after reset", rsp_rdata, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    // Security disabled
    do_reset(1'b0);
    rd(4'h0, 1'b1, 1'b1, "R1 mask reset zero");
    wr(4'h0, 32'h0000_3FFF, 4'hF, 1'b1, 1'b1, "R5 write ignored");
    rd(4'h0, 1'b1, 1'b1, "R5 mask reads zero");
    rd(4'h0, 1'b0, 1'b0, "R5 untrusted read no event");
    wr(4'h4, 32'h0, 4'hF, 1'b0, 1'b1, "R5 untrusted write no event");
    rd(4'h4, 1'b1, 1'b1, "R5 status reads zero");
    sec_enable = 1'b1;
    idle('0, "R5 enable on");
    rd(4'h4, 1'b1, 1'b1, "R5 no self event while off");
    rd(4'h0, 1'b1, 1'b1, "R5 mask held zero");
    // Security enabled
    do_reset(1'b1);
    rd(4'h0, 1'b1, 1'b1, "R1 mask reset ones");
    rd(4'h4, 1'b1, 1'b1, "R1 status reset zero");
    rd(4'h0, 1'b0, 1'b1, "R3 nonsecure read zero");
    idle('0, "R9 self flag raises irq");
    rd(4'h4, 1'b1, 1'b1, "R4 self flag set");
    wr(4'h8, 32'h1, 4'hF, 1'b1, 1'b1, "R7 clear bit0");
    rd(4'h4, 1'b1, 1'b1, "R7 status after clear");
    wr(4'h0, 32'h0, 4'h1, 1'b1, 1'b1, "R2 low lane write");
    rd(4'h0, 1'b1, 1'b1, "R2 only low lane changed");
    wr(4'h0, 32'h0, 4'hC, 1'b1, 1'b1, "R2 reserved lanes");
    rd(4'h0, 1'b1, 1'b1, "R2 reserved unchanged");
    wr(4'h0, 32'h0, 4'hF, 1'b1, 1'b0, "R3 unprivileged write");
    rd(4'h0, 1'b1, 1'b1, "R3 mask unchanged");
    idle(14'h0008, "R6 masked event");
    idle('0, "R6 masked no irq");
    rd(4'h4, 1'b1, 1'b1, "R6 flag set while masked");
    wr(4'h8, 32'h0000_0008, 4'hE, 1'b1, 1'b1, "R7 clear strobe off");
    rd(4'h4, 1'b1, 1'b1, "R7 flag kept without strobe");
    cyc(1'b1, 1'b1, 4'h8, 32'h0000_0400, 4'hF, 1'b1, 1'b1, 14'h0400, "R8 event and clear");
    rd(4'h4, 1'b1, 1'b1, "R8 event wins");
    idle('0, "R9 irq from bit10");
    // Random mix
    for (int k = 0; k < 3000; k++) begin
      logic [AW-1:0] a;
      logic [NSRC-1:0] ev;
      a  = {2'($urandom % 4), 2'b00};
      ev = (($urandom % 6) == 0) ? NSRC'($urandom) : '0;
      cyc(1'($urandom), 1'($urandom), a, $urandom, 4'($urandom),
          (($urandom % 4) != 0), (($urandom % 4) != 0), ev, "RAND");
    end
    finish_run();
  end
endmodule